// File: doc/BRIEF.md
# Serial Flash Slave Front End with Pause Control

This block is the pin-facing serial front end for the slave side of a serial flash device. It runs on a fast system clock and brings the four serial pins (clock, active-low select, data in, active-low pause) through synchronizers. It then finds the serial clock edges from the sampled values. Rising serial-clock edges shift input bits in, most significant bit first, and a one-cycle strobe marks each completed byte. Falling edges shift the response byte out, also most significant bit first, and the controller supplies that byte on a parallel input. Clock idle-low (polarity 0, phase 0) and clock idle-high (polarity 1, phase 1) both work without any setting, because both sample on the rising edge and shift on the falling edge.

The block counts serial clock pulses while selected. When select is released it reports a deselect event, together with a flag telling whether the pulse count ended exactly on a byte boundary. This lets the instruction decoder reject sequences that stop partway through a byte. The pause (hold) condition freezes the serial state without deselecting. Both its entry and its exit take effect only while the serial clock is low. A release of select during a pause resets the serial logic, and the device will not respond again until the pause pin is high at a fresh falling edge of select. After reset, the block also stays unresponsive until it has seen a falling edge of select.

Top module: `sflash_serial_front`

## Requirements
- R1: While reset is asserted, all outputs are 0: `sdo_o`, `sdo_oe_o`, `rx_valid_o`, `tx_load_o`, `hold_o`, `desel_o` and `desel_aligned_o`.
- R2: While selected and not paused, each rising serial clock edge shifts `sdi_i` in, MSB first. Every 8th rising edge since select pulses `rx_valid_o` for exactly one system cycle, with the assembled byte on `rx_byte_o`. This holds with the clock idling low and with the clock idling high.
- R3: On the first falling serial clock edge after a completed byte, `tx_byte_i` is taken and `tx_load_o` pulses for one cycle. From then on, `sdo_o` presents that byte MSB first, and each later falling edge within the byte moves it to the next bit. Before the first completed byte of a selection, `sdo_o` is 0.
- R4: `sdo_oe_o` is 1 only while select is low, the device is armed and no pause is active. Otherwise it is 0 and `sdo_o` is 0.
- R5: A pause starts only when `holdn_i` is low while the serial clock is low. If `holdn_i` falls while the clock is high, the pause starts when the clock next goes low.
- R6: A pause ends only when `holdn_i` is high while the serial clock is low. If `holdn_i` rises while the clock is high, the pause ends when the clock next goes low.
- R7: During a pause, serial clock edges and `sdi_i` have no effect. A byte interrupted by a pause completes with the bits sent before and after the pause.
- R8: A pause can only be active while select is low. `hold_o` is never set while deselected.
- R9: Releasing select during a pause clears the pause, produces no deselect event and discards the partial byte. Later bytes are accepted only after a falling edge of select that occurs while `holdn_i` is high.
- R10: After reset, the block ignores serial traffic until it sees a falling edge of select. If select is already low when reset is released, no byte, output enable or deselect event occurs until select has risen and fallen again.
- R11: Releasing select while armed and not paused pulses `desel_o` for one cycle. `desel_aligned_o` is 1 in that cycle exactly when the number of rising clock edges since select is nonzero and a multiple of 8.
- R12: Each selection starts byte assembly from bit 0, and bits left over from an earlier selection are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin |
| csn_i | input | 1 | Active-low select pin |
| sdi_i | input | 1 | Serial data in |
| holdn_i | input | 1 | Active-low pause request |
| tx_byte_i | input | 8 | Response byte, taken at the start of each byte after the first |
| tx_load_o | output | 1 | One-cycle pulse when `tx_byte_i` is taken |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for the tri-state data pin |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe per received byte |
| hold_o | output | 1 | Pause condition active |
| desel_o | output | 1 | One-cycle pulse on an ordinary deselect |
| desel_aligned_o | output | 1 | Pulse count at deselect was a nonzero multiple of 8 |

## Verification
The bench builds the block with its default 8-bit byte and two synchronizer stages. Each serial half period lasts six system cycles, which is more than the three-cycle path from pin to register, so every serial edge is resolved before the next one. At this size, a sweep over every transfer length from 0 to 24 clock pulses in both clock polarities is cheap. That sweep hits every position of the deselect relative to a byte boundary and every count of loaded response bytes. Directed sequences then place pause entry and exit with the clock high and with the clock low, release select during a pause, and hold select low through reset.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  // Index of the next bit in a byte of w bits, wrapping to 0.
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned w);
    return (idx + 1 >= w) ? 0 : idx + 1;
  endfunction

  // A deselect is aligned when pulses were seen and the bit index is back at 0.
  function automatic logic boundary_ok(input logic seen, input int unsigned idx);
    return seen && (idx == 0);
  endfunction

  // Index of the last bit in a byte of w bits.
  function automatic int unsigned last_idx(input int unsigned w);
    return w - 1;
  endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sfe_hold_ctl.sv
module sfe_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_s,
  input  logic sck_s,
  input  logic holdn_s,
  output logic armed,
  output logic hold_q,
  output logic desel_evt
);
  logic csn_prev;
  logic csn_fall;
  logic armed_d;
  logic hold_d;

  assign csn_fall = csn_prev && !csn_s;

  always_comb begin
    armed_d = armed;
    if (csn_s)                    armed_d = 1'b0;
    else if (csn_fall && holdn_s) armed_d = 1'b1;
  end

  always_comb begin
    hold_d = hold_q;
    if (csn_s || !armed)                    hold_d = 1'b0;
    else if (!hold_q && !holdn_s && !sck_s) hold_d = 1'b1;
    else if (hold_q && holdn_s && !sck_s)   hold_d = 1'b0;
  end

  // Ordinary deselect: select rises while armed and not paused.
  assign desel_evt = csn_s && armed && !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_prev <= 1'b0;
      armed    <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      csn_prev <= csn_s;
      armed    <= armed_d;
      hold_q   <= hold_d;
    end
  end

  // R5
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(!sck_s && !holdn_s && !csn_s));

  // R6
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(csn_s || !armed || (!sck_s && holdn_s)));

  // R8
  hold_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !hold_q);

  // R9
  arm_needs_holdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(holdn_s && !csn_s));
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
  parameter int BYTE_W = 8,
  localparam int IW    = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              tx_load,
  output logic              sdo_bit,
  output logic              seen,
  output logic [IW-1:0]     idx
);
  localparam logic [IW-1:0] LAST = IW'(sfe_pkg::last_idx(BYTE_W));

  logic [BYTE_W-2:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;

  assign sdo_bit = tx_sr[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr    <= '0;
      tx_sr    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      seen     <= 1'b0;
      idx      <= '0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (clr) begin
        rx_sr <= '0;
        tx_sr <= '0;
        seen  <= 1'b0;
        idx   <= '0;
      end else if (en) begin
        if (rise) begin
          rx_sr <= {rx_sr[BYTE_W-3:0], sdi};
          seen  <= 1'b1;
          idx   <= IW'(sfe_pkg::wrap_inc(32'(idx), BYTE_W));
          if (idx == LAST) begin
            rx_byte  <= {rx_sr, sdi};
            rx_valid <= 1'b1;
          end
        end else if (fall) begin
          if (idx == '0 && seen) begin
            tx_sr   <= tx_byte;
            tx_load <= 1'b1;
          end else if (idx != '0) begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  // R2
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R3
  tx_load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);

  // R7
  frozen_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(idx) && $stable(seen));

  // R12
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0) && !seen);
endmodule

// File: rtl/sflash_serial_front.sv
module sflash_serial_front #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic              holdn_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              tx_load_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              hold_o,
  output logic              desel_o,
  output logic              desel_aligned_o
);
  localparam int IW = $clog2(BYTE_W);

  logic [3:0]    pins_s;
  logic          sck_s, csn_s, sdi_s, holdn_s;
  logic          sck_prev;
  logic          sck_rise, sck_fall;
  logic          armed, hold_q, desel_evt;
  logic          live;
  logic          sdo_bit, seen;
  logic [IW-1:0] idx;

  sfe_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sck_i, csn_i, sdi_i, holdn_i}),
    .dout (pins_s)
  );
  assign {sck_s, csn_s, sdi_s, holdn_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;

  assign sck_rise = sck_s && !sck_prev;
  assign sck_fall = !sck_s && sck_prev;

  sfe_hold_ctl u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (csn_s),
    .sck_s    (sck_s),
    .holdn_s  (holdn_s),
    .armed    (armed),
    .hold_q   (hold_q),
    .desel_evt(desel_evt)
  );

  assign live = armed && !hold_q && !csn_s;

  sfe_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!armed),
    .en      (live),
    .rise    (sck_rise),
    .fall    (sck_fall),
    .sdi     (sdi_s),
    .tx_byte (tx_byte_i),
    .rx_byte (rx_byte_o),
    .rx_valid(rx_valid_o),
    .tx_load (tx_load_o),
    .sdo_bit (sdo_bit),
    .seen    (seen),
    .idx     (idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desel_o         <= 1'b0;
      desel_aligned_o <= 1'b0;
    end else begin
      desel_o         <= desel_evt;
      desel_aligned_o <= desel_evt && sfe_pkg::boundary_ok(seen, 32'(idx));
    end
  end

  assign sdo_oe_o = live;
  assign sdo_o    = live && sdo_bit;
  assign hold_o   = hold_q;

  // R4
  oe_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o |-> (!csn_s && !hold_o && armed));

  // R11
  aligned_with_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_aligned_o |-> desel_o);

  // R9
  no_event_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && csn_s) |=> !desel_o);
endmodule

// File: tb/sflash_serial_front_bench.sv
module sflash_serial_front_bench;
  localparam int H = 6;

  logic       clk, rst_n;
  logic       sck, csn, sdi, holdn;
  logic [7:0] tx;
  logic       tx_load_o, sdo_o, sdo_oe_o, rx_valid_o, hold_o, desel_o, desel_aligned_o;
  logic [7:0] rx_byte_o;

  int         checks = 0;
  int         errors = 0;
  int         rx_n = 0, desel_n = 0, tl_n = 0;
  logic       last_aligned = 1'b0;
  logic [7:0] rx_log [64];
  logic [7:0] rsp [4];
  bit         done = 0;

  sflash_serial_front u_sflash_serial_front (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi), .holdn_i(holdn),
    .tx_byte_i(tx), .tx_load_o(tx_load_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o), .hold_o(hold_o),
    .desel_o(desel_o), .desel_aligned_o(desel_aligned_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid_o) begin rx_log[rx_n % 64] <= rx_byte_o; rx_n <= rx_n + 1; end
      if (desel_o)    begin desel_n <= desel_n + 1; last_aligned <= desel_aligned_o; end
      if (tx_load_o)  tl_n <= tl_n + 1;
    end
  end

  function automatic logic [7:0] pat(input int mode, input int k);
    return 8'(8'h3C + 37 * k + 5 * mode);
  endfunction

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rise_bit(input logic b, output logic smp);
    sdi = b;
    wait_c(H);
    smp = sdo_o;
    sck = 1'b1;
    wait_c(H);
  endtask

  task automatic clock_bit(input int mode, input logic b, output logic smp);
    if (mode == 3) begin
      sck = 1'b0;
      rise_bit(b, smp);
    end else begin
      rise_bit(b, smp);
      sck = 1'b0;
    end
  endtask

  task automatic select_dev();
    csn = 1'b0;
    wait_c(H);
  endtask

  task automatic deselect_dev();
    wait_c(H);
    csn = 1'b1;
    wait_c(2 * H);
  endtask

  task automatic send_byte(input int mode, input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(mode, v[i], s);
  endtask

  // One transfer of n clock pulses in the given mode, checked arithmetically.
  task automatic run_xfer(input int mode, input int n);
    int   rx0, d0, t0, nb, exp_loads;
    logic s;
    sck = (mode == 3);
    tx  = 8'(8'hA5 ^ (n * 11 + mode));
    wait_c(H);
    rx0 = rx_n; d0 = desel_n; t0 = tl_n;
    for (int k = 0; k < 4; k++) rsp[k] = 8'h00;
    select_dev();
    for (int i = 0; i < n; i++) begin
      clock_bit(mode, pat(mode, i / 8)[7 - i % 8], s);
      rsp[i / 8][7 - i % 8] = s;
    end
    deselect_dev();
    nb = n / 8;
    // R11: one event, aligned exactly for nonzero multiples of 8
    chk("R11 desel count", desel_n - d0, 1);
    chk("R11 aligned flag", int'(last_aligned), int'(n > 0 && n % 8 == 0));
    // R2: one strobe per complete byte, MSB first
    chk("R2 byte count", rx_n - rx0, nb);
    for (int k = 0; k < nb; k++) chk("R2 byte value", int'(rx_log[(rx0 + k) % 64]), int'(pat(mode, k)));
    // R3: loads and response bytes
    exp_loads = (mode == 0) ? nb : ((n > 0) ? (n - 1) / 8 : 0);
    chk("R3 load count", tl_n - t0, exp_loads);
    for (int k = 0; k < nb; k++) chk("R3 response byte", int'(rsp[k]), (k == 0) ? 0 : int'(tx));
    // R4: no drive once deselected
    chk("R4 oe after deselect", int'(sdo_oe_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-R actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    int   r0, d0;
    csn = 1'b0; sck = 1'b0; sdi = 1'b0; holdn = 1'b1; tx = 8'h00; rst_n = 1'b0;
    wait_c(4);
    // R1: reset state
    chk("R1 sdo", int'(sdo_o), 0);
    chk("R1 oe", int'(sdo_oe_o), 0);
    chk("R1 rx_valid", int'(rx_valid_o), 0);
    chk("R1 tx_load", int'(tx_load_o), 0);
    chk("R1 hold", int'(hold_o), 0);
    chk("R1 desel", int'(desel_o), 0);
    chk("R1 aligned", int'(desel_aligned_o), 0);
    rst_n = 1'b1;
    wait_c(H);

    // R10: select already low at reset release: ignored
    send_byte(0, 8'hC3);
    chk("R10 no byte before select edge", rx_n, 0);
    chk("R10 no oe before select edge", int'(sdo_oe_o), 0);
    csn = 1'b1;
    wait_c(2 * H);
    chk("R10 no deselect event", desel_n, 0);

    // Sweep of transfer lengths in both modes (R2, R3, R4, R11, R12)
    for (int m = 0; m < 2; m++)
      for (int n = 0; n <= 24; n++)
        run_xfer(m == 0 ? 0 : 3, n);

    // R12: partial bits from the previous selection are discarded
    sck = 1'b0; wait_c(H);
    select_dev();
    for (int i = 0; i < 5; i++) clock_bit(0, 1'b1, s);
    deselect_dev();
    select_dev();
    send_byte(0, 8'h4B);
    deselect_dev();
    chk("R12 fresh byte", int'(rx_log[(rx_n - 1) % 64]), 8'h4B);

    // R5/R7: pause entered with clock low, in mode 0
    r0 = rx_n;
    select_dev();
    clock_bit(0, 1'b1, s); clock_bit(0, 1'b0, s); clock_bit(0, 1'b1, s); clock_bit(0, 1'b1, s);
    chk("R4 oe while active", int'(sdo_oe_o), 1);
    holdn = 1'b0;
    wait_c(H);
    chk("R5 hold with clock low", int'(hold_o), 1);
    chk("R4 oe off in hold", int'(sdo_oe_o), 0);
    for (int j = 0; j < 9; j++) begin
      sdi = j[0]; sck = 1'b1; wait_c(H); sck = 1'b0; wait_c(H);
    end
    chk("R7 no byte during hold", rx_n - r0, 0);
    holdn = 1'b1;
    wait_c(H);
    chk("R6 release with clock low", int'(hold_o), 0);
    clock_bit(0, 1'b0, s); clock_bit(0, 1'b1, s); clock_bit(0, 1'b1, s); clock_bit(0, 1'b0, s);
    deselect_dev();
    chk("R7 byte across hold count", rx_n - r0, 1);
    chk("R7 byte across hold value", int'(rx_log[(rx_n - 1) % 64]), 8'hB6);

    // R5/R6: edges of the pause pin while the clock is high, in mode 3
    r0 = rx_n;
    sck = 1'b1; wait_c(H);
    select_dev();
    clock_bit(3, 1'b0, s); clock_bit(3, 1'b1, s); clock_bit(3, 1'b0, s);
    holdn = 1'b0;
    wait_c(H);
    chk("R5 no hold while clock high", int'(hold_o), 0);
    sck = 1'b0;
    wait_c(H);
    chk("R5 hold at next clock low", int'(hold_o), 1);
    sdi = 1'b0; sck = 1'b1;
    wait_c(H);
    holdn = 1'b1;
    wait_c(H);
    chk("R6 hold kept while clock high", int'(hold_o), 1);
    sck = 1'b0;
    wait_c(H);
    chk("R6 hold ends at next clock low", int'(hold_o), 0);
    rise_bit(1'b1, s);
    clock_bit(3, 1'b1, s); clock_bit(3, 1'b0, s); clock_bit(3, 1'b1, s); clock_bit(3, 1'b0, s);
    deselect_dev();
    chk("R6 byte across hold count", rx_n - r0, 1);
    chk("R6 byte across hold value", int'(rx_log[(rx_n - 1) % 64]), 8'h5A);

    // R9: deselect during pause
    sck = 1'b0; wait_c(H);
    r0 = rx_n; d0 = desel_n;
    select_dev();
    clock_bit(0, 1'b1, s); clock_bit(0, 1'b1, s); clock_bit(0, 1'b0, s);
    holdn = 1'b0;
    wait_c(H);
    chk("R9 hold before deselect", int'(hold_o), 1);
    csn = 1'b1;
    wait_c(2 * H);
    chk("R9 hold cleared", int'(hold_o), 0);
    chk("R9 no deselect event", desel_n - d0, 0);
    csn = 1'b0;
    wait_c(H);
    chk("R9 not rearmed with hold low", int'(sdo_oe_o), 0);
    holdn = 1'b1;
    wait_c(H);
    send_byte(0, 8'h77);
    chk("R9 bytes ignored until reselect", rx_n - r0, 0);
    csn = 1'b1;
    wait_c(2 * H);
    select_dev();
    send_byte(0, 8'h96);
    deselect_dev();
    chk("R9 resumes after reselect", rx_n - r0, 1);
    chk("R9 resumed byte", int'(rx_log[(rx_n - 1) % 64]), 8'h96);

    // R8: pause pin low while deselected
    holdn = 1'b0;
    wait_c(2 * H);
    chk("R8 no hold while deselected", int'(hold_o), 0);
    holdn = 1'b1;
    wait_c(H);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule